// File: doc/BRIEF.md
# Stacked Register Window Renamer

This block translates a 7-bit architectural register number into an index of a 128-entry physical general register file. Numbers 0 to 31 are static and pass straight through. Numbers 32 to 127 address the current procedure's frame. That frame sits on a circular pool of 96 stacked physical registers. Its first part holds locals and the rest holds outputs, and an allocate operation sets the size of each part.

A call moves the frame base forward by the caller's local count. The caller's outputs therefore appear to the callee at register 32 with no copying. The callee starts with zero locals and a frame made of just those outputs. A return restores the caller's base and sizes from a 16-entry internal marker stack.

Lookups use a valid/ready request and a one-entry registered response. A request is taken when `req_ready_o` is high. That happens when no response is held, or when the held response is consumed in the same cycle. A response stays unchanged until `rsp_ready_i` takes it. The lookup always uses the frame state from before any control operation in the same cycle. A spill-needed flag reports when the registers held by all live frames exceed the stacked pool.

Top module: `rwin_renamer`

## Requirements
- R1: Architectural registers 0 to 31 map to the same physical index with no fault, whatever the frame state; register 0 always maps to index 0.
- R2: A stacked register a, with offset a-32 below the current frame size, maps to physical index 32 + ((base + a - 32) mod 96) with no fault.
- R3: A stacked register with offset a-32 at or beyond the current frame size raises the fault bit and returns physical index 0.
- R4: Allocate with L locals and O outputs sets the frame size to L+O and the local count to L, without moving the base. An allocate with L+O above 96 is ignored.
- R5: A call moves the base to (base + L) mod 96, sets the frame size to O and the local count to 0. The caller's first output register therefore becomes the callee's register 32.
- R6: A return restores the base, local count and frame size that held just before the matching call.
- R7: The marker stack holds 16 frames. A call while 16 markers are held is ignored, and so is a return while none are held.
- R8: The spill flag is high exactly when the sum of the local counts of all suspended callers plus the current frame size exceeds 96.
- R9: `req_ready_o` = !`rsp_valid_o` || `rsp_ready_i`. A response is held with stable index and fault until taken, and it reflects the frame state before any control operation in the accepting cycle.
- R10: After reset the base and all sizes are zero, and the marker stack is empty. No response is valid, the request side is ready, and the spill flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call: shift the window onto the outputs |
| ret_i | input | 1 | Return: restore the caller's frame |
| alloc_i | input | 1 | Allocate: set the local and output counts |
| alloc_locals_i | input | 7 | Local count for allocate |
| alloc_outs_i | input | 7 | Output count for allocate |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Lookup request ready |
| req_reg_i | input | 7 | Architectural register number |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_ready_i | input | 1 | Lookup response taken |
| rsp_phys_o | output | 7 | Physical register index |
| rsp_fault_o | output | 1 | Out-of-frame fault |
| spill_needed_o | output | 1 | Live frames exceed the stacked pool |

## Verification
The assertions assume that no more than one of call, return and allocate is high in any cycle. The control-operation tasks in the bench drive exactly one of them, for a single cycle each, which keeps the stimulus inside that assumption. Lookups may coincide with a control operation, and one check does this on purpose. The response hold check assumes only that `rsp_ready_i` can stay low for any number of cycles. The bench holds it low across several edges while a new request waits.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  localparam int unsigned STATIC_REGS  = 32;
  localparam int unsigned STACKED_REGS = 96;
  localparam int unsigned TOTAL_REGS   = STATIC_REGS + STACKED_REGS;
  localparam int unsigned REG_W        = $clog2(TOTAL_REGS);
  localparam int unsigned SIZE_W       = $clog2(STACKED_REGS + 1);

  typedef struct packed {
    logic [SIZE_W-1:0] base;
    logic [SIZE_W-1:0] locals;
    logic [SIZE_W-1:0] frame;
  } frame_mark_t;
endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
(
  input  logic [REG_W-1:0]  arch,
  input  logic [SIZE_W-1:0] base,
  input  logic [SIZE_W-1:0] frame,
  output logic [REG_W-1:0]  phys,
  output logic              fault
);
  localparam logic [REG_W:0] K_STATIC = (REG_W+1)'(STATIC_REGS);
  localparam logic [REG_W:0] K_STACK  = (REG_W+1)'(STACKED_REGS);

  logic [REG_W:0] a_x, off, sum;

  always_comb begin
    a_x   = {1'b0, arch};
    off   = '0;
    sum   = '0;
    phys  = '0;
    fault = 1'b0;
    if (a_x < K_STATIC) begin
      phys = arch;
    end else begin
      off = a_x - K_STATIC;
      if (off >= (REG_W+1)'(frame)) begin
        fault = 1'b1;
      end else begin
        sum = off + (REG_W+1)'(base);
        if (sum >= K_STACK) sum = sum - K_STACK;
        phys = REG_W'(sum + K_STATIC);
      end
    end
  end
endmodule

// File: rtl/rwin_stack.sv
module rwin_stack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] K_DEPTH = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] top_idx;

  assign full    = (count == K_DEPTH);
  assign empty   = (count == '0);
  assign top_idx = count - CNT_W'(1);
  assign dout    = mem[top_idx[PTR_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push && !full) begin
      mem[count[PTR_W-1:0]] <= din;
      count <= count + CNT_W'(1);
    end else if (pop && !empty) begin
      count <= count - CNT_W'(1);
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    count <= K_DEPTH);
  assert_full_push_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> full);
  assert_empty_pop_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
  assert_push_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> !empty);
endmodule

// File: rtl/rwin_renamer.sv
module rwin_renamer
  import rwin_pkg::*;
#(
  parameter int unsigned MARK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              alloc_i,
  input  logic [SIZE_W-1:0] alloc_locals_i,
  input  logic [SIZE_W-1:0] alloc_outs_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [REG_W-1:0]  req_reg_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [REG_W-1:0]  rsp_phys_o,
  output logic              rsp_fault_o,
  output logic              spill_needed_o
);
  localparam int unsigned CNT_W = $clog2((MARK_DEPTH + 1) * STACKED_REGS + 1);
  localparam logic [SIZE_W:0] K_STK  = (SIZE_W+1)'(STACKED_REGS);
  localparam logic [CNT_W-1:0] K_POOL = CNT_W'(STACKED_REGS);

  frame_mark_t      cur, top_mark;
  logic             stk_full, stk_empty;
  logic             do_call, do_ret, do_alloc;
  logic [SIZE_W:0]  alloc_sum, next_base;
  logic [CNT_W-1:0] committed;
  logic [REG_W-1:0] map_phys;
  logic             map_fault;
  logic             accept;

  // Frame state: one control operation per cycle, call first.
  assign alloc_sum = {1'b0, alloc_locals_i} + {1'b0, alloc_outs_i};
  assign do_call   = call_i && !stk_full;
  assign do_ret    = ret_i && !call_i && !stk_empty;
  assign do_alloc  = alloc_i && !call_i && !ret_i && (alloc_sum <= K_STK);

  always_comb begin
    next_base = {1'b0, cur.base} + {1'b0, cur.locals};
    if (next_base >= K_STK) next_base = next_base - K_STK;
  end

  rwin_stack #(.DEPTH(MARK_DEPTH), .WIDTH($bits(frame_mark_t))) u_marks (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (do_call),
    .pop   (do_ret),
    .din   (cur),
    .dout  (top_mark),
    .full  (stk_full),
    .empty (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur       <= '0;
      committed <= '0;
    end else if (do_call) begin
      cur.base   <= next_base[SIZE_W-1:0];
      cur.locals <= '0;
      cur.frame  <= cur.frame - cur.locals;
      committed  <= committed + CNT_W'(cur.locals);
    end else if (do_ret) begin
      cur       <= top_mark;
      committed <= committed - CNT_W'(top_mark.locals);
    end else if (do_alloc) begin
      cur.locals <= alloc_locals_i;
      cur.frame  <= alloc_sum[SIZE_W-1:0];
    end
  end

  assign spill_needed_o = (committed + CNT_W'(cur.frame)) > K_POOL;

  // Lookup path with a one-entry response register.
  rwin_map u_map (
    .arch  (req_reg_i),
    .base  (cur.base),
    .frame (cur.frame),
    .phys  (map_phys),
    .fault (map_fault)
  );

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_phys_o  <= '0;
      rsp_fault_o <= 1'b0;
    end else if (accept) begin
      rsp_valid_o <= 1'b1;
      rsp_phys_o  <= map_phys;
      rsp_fault_o <= map_fault;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  assert_one_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({call_i, ret_i, alloc_i}));
  assert_frame_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.frame <= SIZE_W'(STACKED_REGS)) && (cur.locals <= cur.frame));
  assert_call_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    do_call |=> (cur.locals == '0) && (cur.frame == $past(cur.frame - cur.locals)));
  assert_ret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (cur == $past(top_mark)));
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_phys_o) && $stable(rsp_fault_o)));
  assert_fault_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_phys_o == '0));
  assert_static_no_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_reg_i < REG_W'(STATIC_REGS))) |=>
      (!rsp_fault_o && (rsp_phys_o == $past(req_reg_i))));
endmodule

// File: tb/rwin_renamer_tb.sv
`timescale 1ns/1ps
module rwin_renamer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic call_i = 0, ret_i = 0, alloc_i = 0;
  logic [6:0] alloc_locals_i = '0, alloc_outs_i = '0;
  logic req_valid_i = 0, rsp_ready_i = 1;
  logic [6:0] req_reg_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_fault_o, spill_needed_o;
  logic [6:0] rsp_phys_o;

  always #4 clk = ~clk;

  rwin_renamer u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .alloc_i(alloc_i),
    .alloc_locals_i(alloc_locals_i), .alloc_outs_i(alloc_outs_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_reg_i(req_reg_i),
    .rsp_valid_o(rsp_valid_o), .rsp_ready_i(rsp_ready_i), .rsp_phys_o(rsp_phys_o),
    .rsp_fault_o(rsp_fault_o), .spill_needed_o(spill_needed_o)
  );

  int n_chk = 0, n_fail = 0;
  int m_base = 0, m_loc = 0, m_frame = 0, m_comm = 0, m_depth = 0;
  int s_base[16], s_loc[16], s_frame[16];
  bit done = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expect_rsp(input int a);
    int off;
    if (a < 32) return 256 + a;
    off = a - 32;
    if (off >= m_frame) return 256 + 128;
    return 256 + 32 + ((m_base + off) % 96);
  endfunction

  function automatic int got_rsp();
    return (int'(rsp_valid_o) << 8) + (int'(rsp_fault_o) << 7) + int'(rsp_phys_o);
  endfunction

  function automatic string tag_of(input int a);
    if (a < 32) return "R1";
    if (a - 32 >= m_frame) return "R3";
    return "R2";
  endfunction

  task automatic lookup(input int a);
    @(negedge clk);
    req_valid_i = 1; req_reg_i = 7'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 0;
    check(tag_of(a), got_rsp(), expect_rsp(a));
  endtask

  task automatic sweep();
    for (int a = 0; a < 128; a++) lookup(a);
  endtask

  task automatic check_spill();
    check("R8 spill", int'(spill_needed_o), (m_comm + m_frame > 96) ? 1 : 0);
  endtask

  task automatic do_alloc(input int l, input int o);
    @(negedge clk);
    alloc_i = 1; alloc_locals_i = 7'(l); alloc_outs_i = 7'(o);
    @(posedge clk);
    @(negedge clk);
    alloc_i = 0;
    if (l + o <= 96) begin m_loc = l; m_frame = l + o; end
    check_spill();
  endtask

  task automatic do_call();
    @(negedge clk);
    call_i = 1;
    @(posedge clk);
    @(negedge clk);
    call_i = 0;
    if (m_depth < 16) begin
      s_base[m_depth] = m_base; s_loc[m_depth] = m_loc; s_frame[m_depth] = m_frame;
      m_depth++;
      m_comm += m_loc;
      m_base = (m_base + m_loc) % 96;
      m_frame -= m_loc;
      m_loc = 0;
    end
    check_spill();
  endtask

  task automatic do_ret();
    @(negedge clk);
    ret_i = 1;
    @(posedge clk);
    @(negedge clk);
    ret_i = 0;
    if (m_depth > 0) begin
      m_depth--;
      m_comm -= s_loc[m_depth];
      m_base = s_base[m_depth]; m_loc = s_loc[m_depth]; m_frame = s_frame[m_depth];
    end
    check_spill();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    check("R10 rsp_valid", int'(rsp_valid_o), 0);
    check("R10 req_ready", int'(req_ready_o), 1);
    check("R10 spill", int'(spill_needed_o), 0);
    sweep();                     // R10/R3: empty frame faults every stacked register

    do_alloc(10, 6);  sweep();   // R4, R2
    do_alloc(50, 47); sweep();   // R4: oversize allocate ignored
    do_alloc(0, 96);  sweep();   // R4: full-pool frame
    do_alloc(40, 20); do_call(); sweep();  // R5: outputs appear at 32
    do_alloc(30, 66); sweep();   // R2 wrap around the pool, R8 spill high

    // R7: fill the marker stack, then one more call is ignored
    for (int i = 0; i < 16; i++) begin
      do_alloc(((i * 7) % 50) + 1, ((i * 5) % 30) + 1);
      do_call();
    end
    sweep();
    do_call(); sweep();          // R7: call with full marker stack ignored

    // R6: unwind, checking every restored frame
    for (int i = 0; i < 16; i++) begin
      do_ret(); sweep();
    end
    do_ret(); sweep();           // R7: return with empty marker stack ignored

    // R9: lookup in the same cycle as an allocate sees the old frame
    do_alloc(4, 4);
    @(negedge clk);
    alloc_i = 1; alloc_locals_i = 7'd20; alloc_outs_i = 7'd20;
    req_valid_i = 1; req_reg_i = 7'd40;
    @(posedge clk);
    @(negedge clk);
    alloc_i = 0; req_valid_i = 0;
    check("R9 pre-op state", got_rsp(), expect_rsp(40));
    m_loc = 20; m_frame = 40;
    lookup(40);

    // R9: back-pressure holds the response and blocks new requests
    @(negedge clk);
    rsp_ready_i = 0; req_valid_i = 1; req_reg_i = 7'd33;
    @(posedge clk);
    @(negedge clk);
    req_reg_i = 7'd34;
    check("R9 ready low", int'(req_ready_o), 0);
    check("R9 first rsp", got_rsp(), expect_rsp(33));
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R9 held rsp", got_rsp(), expect_rsp(33));
    rsp_ready_i = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 0;
    check("R9 next rsp", got_rsp(), expect_rsp(34));
    @(posedge clk);
    @(negedge clk);
    check("R9 drained", int'(rsp_valid_o), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule